// File: doc/BRIEF.md
# Two-Line Interrupt Router

This block gathers level-sensitive interrupt requests from up to 32 on-chip peripheral sources. Each source is gated by an enable bit and then steered to one of two processor request lines. One line is a fast, high-priority request. The other is a normal request. A per-source select bit picks the line, and software sets both bits through a small register bus.

Software finds the interrupting source in two steps. First it reads the fast or normal pending word from this block to learn which peripheral raised the request. Then it reads that peripheral's own status register to learn which event caused it, and clears the event there. Clearing the event drops the source level, and the pending bit follows. The processor decides the priority between the lines: the fast line may preempt a normal service in progress.

Top module: `intc_two_line`

## Requirements
- R1: After reset every enable bit is 0, every select bit is 0 (normal line), and both fiq_o and irq_o are low.
- R2: A read of word 2 returns the source levels sampled at the previous clock edge, whatever the enable and select bits are.
- R3: A source whose enable bit (word 0) is 0 drives neither fiq_o nor irq_o.
- R4: Select bit (word 1) value 1 sends an enabled source to the fast line only. Value 0 sends it to the normal line only.
- R5: A read of word 3 returns raw AND enable AND select. A read of word 4 returns raw AND enable AND NOT select.
- R6: fiq_o is the OR of the word-3 bits and irq_o is the OR of the word-4 bits. Both are registered and follow a source change at the next clock edge. They follow an enable or select write one edge after the write edge.
- R7: Sources are not latched. A line drops at the clock edge after its last contributing source deasserts.
- R8: A write occurs when sel_i and we_i are high on a clock edge, to word 0 or word 1 only. Writes to words 2, 3, 4 and unmapped words change nothing, and reads of unmapped words return 0.
- R9: The two lines are independent, so fiq_o and irq_o can be high together when enabled sources are steered to both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Level-sensitive source requests |
| sel_i | input | 1 | Register access select |
| we_i | input | 1 | Write enable |
| addr_i | input | 3 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from address |
| fiq_o | output | 1 | Fast interrupt request |
| irq_o | output | 1 | Normal interrupt request |

## Verification
The enable write and a source rising can land on the same clock edge. The bench drives a write that enables a source in the same cycle as that source is raised. It then expects the raw pending bit to be set at once while irq_o stays low for one cycle and rises at the following edge. A second pass lowers one source on the same edge as its select bit is flipped. It judges that the line which lost the source falls and the other line stays low.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_ENABLE = 3'd0,
    REG_SELECT = 3'd1,
    REG_RAW    = 3'd2,
    REG_FPEND  = 3'd3,
    REG_NPEND  = 3'd4
  } reg_addr_e;

  localparam int unsigned LINE_FAST = 0;
  localparam int unsigned LINE_NORM = 1;
  localparam int unsigned N_LINES   = 2;
endpackage

// File: rtl/intc_cfg_regs.sv
module intc_cfg_regs
  import intc_pkg::*;
#(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [N_SRC-1:0]  enable_o,
  output logic [N_SRC-1:0]  select_o
);
  logic wr_en, wr_sel;

  assign wr_en  = sel_i && we_i && (addr_i == REG_ENABLE);
  assign wr_sel = sel_i && we_i && (addr_i == REG_SELECT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enable_o <= '0;
      select_o <= '0;
    end else begin
      if (wr_en)  enable_o <= wdata_i[N_SRC-1:0];
      if (wr_sel) select_o <= wdata_i[N_SRC-1:0];
    end
  end

  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;

  assert_enable_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && we_i && addr_i == REG_ENABLE) |=> enable_o == $past(wdata_i[N_SRC-1:0]));

  assert_ro_ignore_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && sel_i && we_i && addr_i != REG_ENABLE && addr_i != REG_SELECT)
      |=> ($stable(enable_o) && $stable(select_o)));
endmodule

// File: rtl/intc_pend.sv
module intc_pend #(
  parameter int unsigned N_SRC = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_i,
  input  logic [N_SRC-1:0] enable_i,
  input  logic [N_SRC-1:0] select_i,
  output logic [N_SRC-1:0] raw_o,
  output logic [N_SRC-1:0] fpend_o,
  output logic [N_SRC-1:0] npend_o
);
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) raw_o <= '0;
    else         raw_o <= src_i;

  assign fpend_o = raw_o & enable_i &  select_i;
  assign npend_o = raw_o & enable_i & ~select_i;
endmodule

// File: rtl/intc_line_drv.sv
module intc_line_drv
  import intc_pkg::*;
#(
  parameter int unsigned N_SRC = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_SRC-1:0]   src_i,
  input  logic [N_SRC-1:0]   enable_i,
  input  logic [N_SRC-1:0]   select_i,
  output logic [N_LINES-1:0] line_o
);
  // Taken from live sources so a line moves one edge after its source.
  for (genvar l = 0; l < N_LINES; l++) begin : g_line
    logic [N_SRC-1:0] route;
    assign route = (l == LINE_FAST) ? select_i : ~select_i;
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) line_o[l] <= 1'b0;
      else         line_o[l] <= |(src_i & enable_i & route);
  end
endmodule

// File: rtl/intc_two_line.sv
module intc_two_line
  import intc_pkg::*;
#(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  src_i,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              fiq_o,
  output logic              irq_o
);
  logic [N_SRC-1:0]   enable_q, select_q, raw_q, fpend, npend;
  logic [N_LINES-1:0] lines;

  intc_cfg_regs #(.N_SRC(N_SRC), .DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni, .sel_i, .we_i, .addr_i, .wdata_i,
    .enable_o(enable_q), .select_o(select_q)
  );

  intc_pend #(.N_SRC(N_SRC)) u_pend (
    .clk_i, .rst_ni, .src_i,
    .enable_i(enable_q), .select_i(select_q),
    .raw_o(raw_q), .fpend_o(fpend), .npend_o(npend)
  );

  intc_line_drv #(.N_SRC(N_SRC)) u_lines (
    .clk_i, .rst_ni, .src_i,
    .enable_i(enable_q), .select_i(select_q),
    .line_o(lines)
  );

  assign fiq_o = lines[LINE_FAST];
  assign irq_o = lines[LINE_NORM];

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      REG_ENABLE: rdata_o = DATA_W'(enable_q);
      REG_SELECT: rdata_o = DATA_W'(select_q);
      REG_RAW:    rdata_o = DATA_W'(raw_q);
      REG_FPEND:  rdata_o = DATA_W'(fpend);
      REG_NPEND:  rdata_o = DATA_W'(npend);
      default:    rdata_o = '0;
    endcase
  end

  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;

  assert_raw_read_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && addr_i == REG_RAW) |-> rdata_o == DATA_W'($past(src_i)));

  assert_fast_match_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $stable(enable_q) && $stable(select_q)) |-> fiq_o == (|fpend));

  assert_norm_match_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $stable(enable_q) && $stable(select_q)) |-> irq_o == (|npend));

  assert_one_line_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fpend & npend) == '0);
endmodule

// File: tb/intc_two_line_bench.sv
module intc_two_line_bench;
  localparam int N = 32;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [N-1:0]  src_i = '0;
  logic          sel_i = 1'b0, we_i = 1'b0;
  logic [2:0]    addr_i = '0;
  logic [31:0]   wdata_i = '0;
  logic [31:0]   rdata_o;
  logic          fiq_o, irq_o;

  int applied = 0, bad = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  intc_two_line u_intc_two_line (.*);

  typedef struct packed {
    logic [31:0] en;
    logic [31:0] sl;
    logic [31:0] src;
    logic        ef;
    logic        ei;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0001, 1'b0, 1'b1},
    '{32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0001, 1'b1, 1'b0},
    '{32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0},
    '{32'h0000_00F0, 32'h0000_0030, 32'h0000_0010, 1'b1, 1'b0},
    '{32'h0000_00F0, 32'h0000_0030, 32'h0000_0080, 1'b0, 1'b1},
    '{32'h8000_0000, 32'h8000_0000, 32'h8000_0001, 1'b1, 1'b0},
    '{32'hFFFF_0000, 32'h0000_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b1},
    '{32'h0000_000F, 32'h0000_0005, 32'h0000_000F, 1'b1, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    applied++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    sel_i = 1; we_i = 1; addr_i = a; wdata_i = d;
    @(posedge clk_i); @(negedge clk_i);
    sel_i = 0; we_i = 0;
  endtask

  function automatic logic [31:0] rd(input logic [2:0] a);
    addr_i = a;
    return rdata_o;
  endfunction

  task automatic rdchk(input string req, input logic [2:0] a, input logic [31:0] exp);
    addr_i = a; #1;
    check(req, rdata_o, exp);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R1 reset state
    check("R1 fiq", {31'b0, fiq_o}, 0);
    check("R1 irq", {31'b0, irq_o}, 0);
    rdchk("R1 enable", 3'd0, 0);
    rdchk("R1 select", 3'd1, 0);
    // R3: all sources high while masked
    src_i = '1;
    @(posedge clk_i); @(negedge clk_i);
    check("R3 fiq masked", {31'b0, fiq_o}, 0);
    check("R3 irq masked", {31'b0, irq_o}, 0);
    rdchk("R2 raw masked", 3'd2, 32'hFFFF_FFFF);
    src_i = '0;
    @(posedge clk_i); @(negedge clk_i);

    // Table walk: R3 R4 R5 R6 R9
    foreach (VECS[i]) begin
      wr(3'd0, VECS[i].en);
      wr(3'd1, VECS[i].sl);
      src_i = VECS[i].src;
      @(posedge clk_i); @(negedge clk_i);
      check("R6 fiq", {31'b0, fiq_o}, {31'b0, VECS[i].ef});
      check("R6 irq", {31'b0, irq_o}, {31'b0, VECS[i].ei});
      rdchk("R2 raw", 3'd2, VECS[i].src);
      rdchk("R5 fast pend", 3'd3, VECS[i].src & VECS[i].en & VECS[i].sl);
      rdchk("R5 norm pend", 3'd4, VECS[i].src & VECS[i].en & ~VECS[i].sl);
    end

    // R8: writes to read-only and unmapped words change nothing
    wr(3'd2, 32'h1234_5678);
    wr(3'd3, 32'hFFFF_FFFF);
    wr(3'd7, 32'hFFFF_FFFF);
    rdchk("R8 enable kept", 3'd0, 32'h0000_000F);
    rdchk("R8 select kept", 3'd1, 32'h0000_0005);
    rdchk("R8 raw kept", 3'd2, 32'h0000_000F);
    rdchk("R8 unmapped", 3'd6, 0);
    // R9 both lines high together (last vector)
    check("R9 both", {30'b0, fiq_o, irq_o}, 32'd3);

    // R7: level only, lines drop one edge after sources drop
    src_i = '0;
    @(posedge clk_i); @(negedge clk_i);
    check("R7 fiq drop", {31'b0, fiq_o}, 0);
    check("R7 irq drop", {31'b0, irq_o}, 0);

    // Same edge: enable write and source rise (R6)
    wr(3'd0, 32'h0);
    wr(3'd1, 32'h0);
    sel_i = 1; we_i = 1; addr_i = 3'd0; wdata_i = 32'h0000_0008;
    src_i = 32'h0000_0008;
    @(posedge clk_i); @(negedge clk_i);
    sel_i = 0; we_i = 0;
    check("R6 same edge irq low", {31'b0, irq_o}, 0);
    rdchk("R2 same edge raw", 3'd2, 32'h0000_0008);
    @(posedge clk_i); @(negedge clk_i);
    check("R6 next edge irq high", {31'b0, irq_o}, 1);
    check("R4 fiq stays low", {31'b0, fiq_o}, 0);

    // Same edge: source drop and select flip (R7, R4)
    sel_i = 1; we_i = 1; addr_i = 3'd1; wdata_i = 32'h0000_0008;
    src_i = '0;
    @(posedge clk_i); @(negedge clk_i);
    sel_i = 0; we_i = 0;
    check("R7 irq falls", {31'b0, irq_o}, 0);
    @(posedge clk_i); @(negedge clk_i);
    check("R4 fiq stays low after flip", {31'b0, fiq_o}, 0);
    check("R7 irq stays low", {31'b0, irq_o}, 0);

    // R1: reset in mid-operation clears config
    rst_ni = 0; #1;
    check("R1 fiq in reset", {31'b0, fiq_o}, 0);
    rst_ni = 1;
    @(negedge clk_i);
    rdchk("R1 enable after reset", 3'd0, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule